// File: doc/BRIEF.md
# Diagnostic FIFO Access Port

This block gives test software direct entry to a display-data FIFO through a single 32-bit register, without going through the normal fill path. The FIFO stores 64-bit entries. Software builds each entry from two register writes: the first write supplies the low word and the second the high word. The second write commits the whole entry and advances the write pointer. On the read side, an output latch prefetches one entry at a time. Software must start with one dummy read. That read returns a meaningless value, and its only job is to fill the latch from the entry at the read pointer. Each later read returns one half of the latched entry, low half first. After the high half has been read, the read pointer advances.

Every accepted read starts a fixed shift window. The latch is refilled from the storage at the end of that window, and a busy flag stays high for the whole window. The write side is a two-state machine: `WR_LOW` waits for a low word and `WR_HIGH` waits for the high word that commits the entry. It moves from `WR_LOW` to `WR_HIGH` on an accepted write and back to `WR_LOW` on the next accepted write. The read side is a three-state machine:
- `RD_UNPRIMED` waits for the priming read and moves to `RD_SHIFT` when one arrives.
- `RD_SHIFT` counts the shift window and moves to `RD_READY` on its last cycle, loading the latch at that point.
- `RD_READY` serves reads and moves back to `RD_SHIFT` on each accepted read.

A rising diagnostic enable sends both machines back to their first state.

Top module: `dfifo_diag_port`

## Requirements
- R1: A register read or write is accepted only in a cycle where `diag_en` is 1 and `load_en` is 0. A strobe in any other cycle changes no pointer, half-select, latch or busy state.
- R2: The first accepted write of a pair sets bits 31:0 of the entry and the second sets bits 63:32. The entry is committed and the write pointer advances by one on the second write.
- R3: The first accepted read after entering diagnostic mode is the priming read. Its data is don't-care. It loads the entry at the read pointer into the latch and leaves the pointer unchanged.
- R4: Reads after the priming read return, in the cycle of the read strobe, first the low half and then the high half of each entry, in the order the entries were written.
- R5: The read pointer advances by one on the accepted read that returns a high half.
- R6: `busy` is 1 for exactly SHIFT_CYC (default 4) cycles, starting the cycle after each accepted read. The latch is refilled on the last of those cycles, and `busy` is 0 once the window ends.
- R7: A read strobe while `busy` is 1 is a protocol violation and is flagged by an assertion.
- R8: A rising edge of `diag_en` clears both pointers and both half-selects and returns the read side to `RD_UNPRIMED`. A strobe in that same cycle is discarded.
- R9: Both pointers wrap modulo DEPTH (default 16). Writing DEPTH+2 entries overwrites slots 0 and 1.
- R10: After reset, `busy` is 0 and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| diag_en | input | 1 | Diagnostic mode enable |
| load_en | input | 1 | Normal FIFO load enable; blocks diagnostic access when high |
| reg_rd | input | 1 | Decoded read strobe of the access register |
| reg_wr | input | 1 | Decoded write strobe of the access register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Selected half of the output latch |
| busy | output | 1 | Latch shift window in progress |

## Verification
The assertions assume that software never issues an accepted read while `busy` is high, and that it leaves at least one idle cycle after `diag_en` rises before it starts accessing the port. The stimulus holds each read strobe for one cycle and then waits until `busy` has been seen low again before it issues the next read. It also waits two cycles after every entry into diagnostic mode. The strobes that are sent while access is blocked are sent with `load_en` high, so they never come close to a shift window.

// File: rtl/dfifo_diag_pkg.sv
package dfifo_diag_pkg;
    typedef enum logic {
        WR_LOW,
        WR_HIGH
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_UNPRIMED,
        RD_SHIFT,
        RD_READY
    } rd_state_e;
endpackage

// File: rtl/dfifo_diag_wr.sv
module dfifo_diag_wr
    import dfifo_diag_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [DW-1:0]   wdata,
    output logic            commit,
    output logic [AW-1:0]   commit_addr,
    output logic [2*DW-1:0] commit_data
);
    wr_state_e     state, state_nxt;
    logic [DW-1:0] low_q;
    logic [AW-1:0] wr_ptr;

    always_comb begin
        state_nxt = state;
        if (clr) begin
            state_nxt = WR_LOW;
        end else if (wr_en) begin
            unique case (state)
                WR_LOW:  state_nxt = WR_HIGH;
                WR_HIGH: state_nxt = WR_LOW;
                default: state_nxt = WR_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_LOW;
        else        state <= state_nxt;
    end

    assign commit      = wr_en && !clr && (state == WR_HIGH);
    assign commit_addr = wr_ptr;
    assign commit_data = {wdata, low_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= '0;
            wr_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            if (state == WR_LOW) low_q  <= wdata;
            else                 wr_ptr <= wr_ptr + 1'b1;
        end
    end

    AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(wr_ptr)); // R1
    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && state == WR_HIGH) |=> (wr_ptr == $past(wr_ptr) + 1'b1)); // R2
    AST_WPTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wr_ptr == '0 && state == WR_LOW)); // R8
endmodule

// File: rtl/dfifo_diag_store.sv
module dfifo_diag_store #(
    parameter int DEPTH = 16,
    parameter int EW    = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);
    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dfifo_diag_rd.sv
module dfifo_diag_rd
    import dfifo_diag_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DW        = 32,
    parameter int SHIFT_CYC = 4,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(SHIFT_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            rd_en,
    input  logic [2*DW-1:0] entry,
    output logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rdata,
    output logic            busy
);
    rd_state_e       state, state_nxt;
    logic [CW-1:0]   cnt;
    logic [AW-1:0]   rd_ptr;
    logic            half;
    logic [2*DW-1:0] latch_q;
    logic            last_shift;

    assign last_shift = (state == RD_SHIFT) && (cnt == CW'(SHIFT_CYC - 1));

    always_comb begin
        state_nxt = state;
        if (clr) begin
            state_nxt = RD_UNPRIMED;
        end else begin
            unique case (state)
                RD_UNPRIMED: if (rd_en) state_nxt = RD_SHIFT;
                RD_SHIFT:    if (last_shift) state_nxt = RD_READY;
                RD_READY:    if (rd_en) state_nxt = RD_SHIFT;
                default:     state_nxt = RD_UNPRIMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_UNPRIMED;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rd_ptr  <= '0;
            half    <= 1'b0;
            latch_q <= '0;
        end else if (clr) begin
            cnt    <= '0;
            rd_ptr <= '0;
            half   <= 1'b0;
        end else begin
            cnt <= (state == RD_SHIFT && !last_shift) ? cnt + 1'b1 : '0;
            if (last_shift) latch_q <= entry;
            if (state == RD_READY && rd_en) begin
                half <= !half;
                if (half) rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    assign rd_addr = rd_ptr;
    assign busy    = (state == RD_SHIFT);
    assign rdata   = half ? latch_q[2*DW-1:DW] : latch_q[DW-1:0];

    AST_PRIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_UNPRIMED && rd_en && !clr) |=> (rd_ptr == $past(rd_ptr) && !half)); // R3
    AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_READY && rd_en && half && !clr) |=> (rd_ptr == $past(rd_ptr) + 1'b1)); // R5
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RD_SHIFT && rd_en && !clr) |=> busy); // R6
    AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < CW'(SHIFT_CYC))); // R6
endmodule

// File: rtl/dfifo_diag_port.sv
module dfifo_diag_port #(
    parameter int DEPTH     = 16,
    parameter int DW        = 32,
    parameter int SHIFT_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          diag_en,
    input  logic          load_en,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          busy
);
    localparam int AW = $clog2(DEPTH);
    localparam int EW = 2 * DW;

    logic          diag_q;
    logic          clr;
    logic          access_ok;
    logic          commit;
    logic [AW-1:0] commit_addr;
    logic [EW-1:0] commit_data;
    logic [AW-1:0] rd_addr;
    logic [EW-1:0] entry;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) diag_q <= 1'b0;
        else        diag_q <= diag_en;
    end

    assign clr       = diag_en && !diag_q;
    assign access_ok = diag_en && !load_en;

    dfifo_diag_wr #(.DEPTH(DEPTH), .DW(DW)) i_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .wr_en       (access_ok && reg_wr),
        .wdata       (reg_wdata),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    dfifo_diag_store #(.DEPTH(DEPTH), .EW(EW)) i_store (
        .clk   (clk),
        .we    (commit),
        .waddr (commit_addr),
        .wdata (commit_data),
        .raddr (rd_addr),
        .rdata (entry)
    );

    dfifo_diag_rd #(.DEPTH(DEPTH), .DW(DW), .SHIFT_CYC(SHIFT_CYC)) i_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .rd_en   (access_ok && reg_rd),
        .entry   (entry),
        .rd_addr (rd_addr),
        .rdata   (reg_rdata),
        .busy    (busy)
    );

    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (access_ok && reg_rd) |-> !busy); // R7
    AST_BLOCKED_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !access_ok) |=> !busy); // R1
endmodule

// File: tb/test_dfifo_diag_port.sv
module test_dfifo_diag_port;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        diag_en = 1'b0;
    logic        load_en = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = !clk;

    dfifo_diag_port i_dfifo_diag_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .diag_en   (diag_en),
        .load_en   (load_en),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy)
    );

    localparam logic [31:0] VEC [16] = '{
        32'h0000_0001, 32'h8000_0000, 32'hDEAD_BEEF, 32'h0123_4567,
        32'hFFFF_FFFF, 32'h0000_0000, 32'h5A5A_5A5A, 32'hA5A5_A5A5,
        32'h1357_9BDF, 32'h2468_ACE0, 32'hCAFE_F00D, 32'h0F0F_0F0F,
        32'h7FFF_FFFF, 32'h0000_8000, 32'h3C3C_C3C3, 32'h9999_6666
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_word(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_word(output logic [31:0] got, input bit accepted);
        @(negedge clk);
        reg_rd = 1'b1;
        #1 got = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        #1 check(accepted ? "R6 busy after read" : "R1 blocked read", 32'(busy), 32'(accepted));
        repeat (3) @(negedge clk);
        #1 if (accepted) check("R6 busy during window", 32'(busy), 32'd1);
        @(negedge clk);
        #1 check("R6 busy cleared", 32'(busy), 32'd0);
    endtask

    task automatic enter_diag();
        @(negedge clk);
        diag_en = 1'b0;
        repeat (2) @(negedge clk);
        diag_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] wrap_word(input int slot, input bit hi);
        int e;
        e = (slot < 2) ? slot + DEPTH : slot;
        return hi ? 32'h2000_0000 + 32'(e) : 32'h1000_0000 + 32'(e);
    endfunction

    initial begin
        logic [31:0] got;
        logic [31:0] q[$];
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        #1 check("R10 reset busy", 32'(busy), 32'd0);
        check("R10 reset rdata", reg_rdata, 32'd0);
        rst_n = 1'b1;
        enter_diag();

        // R1: writes while load_en is high are ignored
        load_en = 1'b1;
        wr_word(32'hBAD0_0001);
        wr_word(32'hBAD0_0002);
        wr_word(32'hBAD0_0003);
        rd_word(got, 1'b0);
        load_en = 1'b0;

        for (int i = 0; i < 16; i++) begin
            wr_word(VEC[i]);
            q.push_back(VEC[i]);
        end
        rd_word(got, 1'b1); // R3 priming read
        for (int i = 0; i < 16; i++) begin
            rd_word(got, 1'b1);
            exp = q.pop_front();
            check("R4 R2 R5 readback order", got, exp);
        end

        // R8 re-entry clears pointers; R9 wrap on write and read
        enter_diag();
        for (int e = 0; e < DEPTH + 2; e++) begin
            wr_word(32'h1000_0000 + 32'(e));
            wr_word(32'h2000_0000 + 32'(e));
        end
        rd_word(got, 1'b1);
        for (int s = 0; s < DEPTH; s++) begin
            rd_word(got, 1'b1);
            check(s < 2 ? "R9 wrapped slot low" : "R8 reentry low", got, wrap_word(s, 1'b0));
            rd_word(got, 1'b1);
            check(s < 2 ? "R9 wrapped slot high" : "R8 reentry high", got, wrap_word(s, 1'b1));
        end
        rd_word(got, 1'b1);
        check("R9 read pointer wrap", got, wrap_word(0, 1'b0));

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule